// File: doc/BRIEF.md
# Cached Block Protection Checker

This block decides, for every physical memory access, whether the access may proceed. Memory is divided into 1K-word blocks, and a bitmap holds one protection bit per block. When a block's bit is set, the protect-enable output stays low, so the bus cycle is never released and times out. When the bit is clear, protect-enable rises and the cycle completes. While a global initialisation write-protect input is high, every write is refused regardless of the bitmap.

The bitmap is stored as one 16-bit word per 16K-word region. A single cache register holds the word for the region used most recently, together with that region's tag and a valid flag. An access that hits the cache returns its result one clock after the strobe is sampled. An access that misses first loads the cache and so takes one extra clock.

An active-low result-valid output falls only once the protection result is settled. An upstream address-translation stage can use it to gate protect-enable without glitches. That stage's success input must be high before the check begins. The whole check can also be switched off: protect-enable is then released with no lookup, and result-valid never falls. A raw bitmap write port exists so that the table can be filled. How the table is programmed at system level is left to the surrounding logic.

Top module: `blkprot_checker`

## Requirements
- R1: After a clock edge with `rst_n` low: `pen_o` is 0, `valid_n_o` is 1, the cache is invalid, and every bitmap bit is clear.
- R2: `blk_i` is the 1K-word block number. Bits [9:4] select the 16K-word region and bits [3:0] select bit position b of that region's bitmap word. If that bit is 1, `pen_o` stays 0 while `valid_n_o` falls. If it is 0, `pen_o` rises together with the fall of `valid_n_o`.
- R3: An access to the cached region (a hit) presents its result at the first clock edge that samples `strobe_i`, `xlat_ok_i` and `prot_en_i` all high.
- R4: An access to any other region (a miss) loads the cache at that edge and presents its result one edge later, which is one wait state. Later accesses to the same region then hit.
- R5: No check starts while `xlat_ok_i` is low. Until it rises, `pen_o` stays 0 and `valid_n_o` stays 1, even though `strobe_i` is high.
- R6: While `init_wp_i` is 1, a write (`wr_i` = 1) is refused whatever its bitmap bit is. Reads are judged by the bitmap alone.
- R7: With `prot_en_i` low, no lookup happens. `pen_o` rises one edge after the start condition, `valid_n_o` stays 1, and the cache contents are left unchanged.
- R8: While `strobe_i` stays high, the result is held. At the first edge that samples `strobe_i` low, `pen_o` returns to 0 and `valid_n_o` returns to 1.
- R9: A bitmap write (`tbl_we_i`) to the cached region invalidates the cache, so the next access to that region misses and sees the new bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Address strobe, high for the duration of an access |
| xlat_ok_i | input | 1 | Upstream translation succeeded (tie high when there is no translation stage) |
| prot_en_i | input | 1 | Protection checking enabled |
| blk_i | input | 10 | Physical 1K-word block number of the access |
| wr_i | input | 1 | 1 = write access, 0 = read access |
| init_wp_i | input | 1 | Global write protect during initialisation |
| tbl_we_i | input | 1 | Bitmap word write enable |
| tbl_idx_i | input | 6 | Region index of the bitmap word being written |
| tbl_word_i | input | 16 | Bitmap word; bit b protects block b of the region |
| pen_o | output | 1 | Protect-enable: high lets the cycle proceed |
| valid_n_o | output | 1 | Active-low protection-result-valid |

## Verification
The bench counts the clocks from the strobe to the result for a hit and for a miss. A design that skips the wait state on a miss would judge the access with the stale word of the previous region; one that always waits would take two clocks on hits. It rewrites the bitmap word of the cached region and checks the next access to it. Without invalidation, a stale allow or block would show up there. It also holds the strobe while translation is not yet ready, and runs with checking switched off. A design that started early, or that dropped result-valid while disabled, would release the cycle too soon or assert a result that does not exist.

// File: rtl/blkprot_pkg.sv
// Package: shared types for the cached block protection checker.
// Assumes nothing beyond IEEE 1800-2017 enums.
package blkprot_pkg;

    // Controller phases of one access.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for strobe and translation success
        ST_FILL = 2'd1,  // cache being reloaded, one wait state
        ST_DONE = 2'd2   // result presented and held
    } chk_state_t;

endpackage

// File: rtl/blkprot_table.sv
// Module: blkprot_table
// Holds one protection word per region. It has one synchronous write port
// and one combinational read port.
// Assumes: the table is cleared by reset; the write port is driven by
// surrounding programming logic.
module blkprot_table #(
    parameter int TAG_W  = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TAG_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TAG_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    localparam int NREG = 1 << TAG_W;

    logic [WORD_W-1:0] mem [NREG];

    // Clear on reset, otherwise store the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    // Combinational read used for cache fills.
    assign rdata = mem[ridx];

endmodule

// File: rtl/blkprot_cache.sv
// Module: blkprot_cache
// Single-entry cache holding the protection word, tag and valid flag of one
// region.
// Assumes: a fill and an invalidation of the same region never coincide.
module blkprot_cache #(
    parameter int TAG_W  = 6,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [WORD_W-1:0] fill_word,
    input  logic              inv,
    input  logic [TAG_W-1:0]  inv_tag,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [WORD_W-1:0] word
);
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;

    // Load on fill; drop the entry when its region is rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
            word  <= '0;
        end else if (fill) begin
            vld_q <= 1'b1;
            tag_q <= fill_tag;
            word  <= fill_word;
        end else if (inv && vld_q && (inv_tag == tag_q)) begin
            vld_q <= 1'b0;
        end
    end

    // Hit when the entry is valid and the tag matches.
    assign hit = vld_q && (look_tag == tag_q);

endmodule

// File: rtl/blkprot_ctrl.sv
// Module: blkprot_ctrl
// Sequences one access: start, optional cache fill, then the held result.
// The outputs are registered.
// Assumes: the block number, wr and init-protect are stable while the strobe
// is high.
module blkprot_ctrl
    import blkprot_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int WORD_W = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              go,
    input  logic              en,
    input  logic              wr,
    input  logic              init_wp,
    input  logic              hit,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] cword,
    output logic              fill,
    output logic              pen,
    output logic              valid_n
);
    chk_state_t state;
    logic       start;
    logic       blocked;

    // Start condition and protection decision.
    always_comb begin
        start   = (state == ST_IDLE) && strobe && go;
        fill    = start && en && !hit;
        blocked = cword[sel] || (init_wp && wr);
    end

    // Access sequencing and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n || !strobe) begin
            state   <= ST_IDLE;
            pen     <= 1'b0;
            valid_n <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (!en) begin
                            state <= ST_DONE;
                            pen   <= 1'b1;
                        end else if (hit) begin
                            state   <= ST_DONE;
                            pen     <= !blocked;
                            valid_n <= 1'b0;
                        end else begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    state   <= ST_DONE;
                    pen     <= !blocked;
                    valid_n <= 1'b0;
                end
                default: begin
                    state <= ST_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/blkprot_checker.sv
// Module: blkprot_checker (top)
// Checks each access against the per-block protection bitmap through a
// single-region cache.
// Assumes: the table is not written while the strobe is high.
module blkprot_checker #(
    parameter int BLK_AW = 10,
    parameter int SEL_W  = 4,
    localparam int TAG_W  = BLK_AW - SEL_W,
    localparam int WORD_W = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              xlat_ok_i,
    input  logic              prot_en_i,
    input  logic [BLK_AW-1:0] blk_i,
    input  logic              wr_i,
    input  logic              init_wp_i,
    input  logic              tbl_we_i,
    input  logic [TAG_W-1:0]  tbl_idx_i,
    input  logic [WORD_W-1:0] tbl_word_i,
    output logic              pen_o,
    output logic              valid_n_o
);
    logic [TAG_W-1:0]  reg_tag;
    logic [SEL_W-1:0]  reg_sel;
    logic [WORD_W-1:0] tbl_rdata;
    logic [WORD_W-1:0] cache_word;
    logic              cache_hit;
    logic              do_fill;

    // Split the block number into the region tag and the bit select.
    assign reg_tag = blk_i[BLK_AW-1:SEL_W];
    assign reg_sel = blk_i[SEL_W-1:0];

    blkprot_table #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we_i),
        .widx  (tbl_idx_i),
        .wdata (tbl_word_i),
        .ridx  (reg_tag),
        .rdata (tbl_rdata)
    );

    blkprot_cache #(.TAG_W(TAG_W), .WORD_W(WORD_W)) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill      (do_fill),
        .fill_tag  (reg_tag),
        .fill_word (tbl_rdata),
        .inv       (tbl_we_i),
        .inv_tag   (tbl_idx_i),
        .look_tag  (reg_tag),
        .hit       (cache_hit),
        .word      (cache_word)
    );

    blkprot_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (strobe_i),
        .go      (xlat_ok_i),
        .en      (prot_en_i),
        .wr      (wr_i),
        .init_wp (init_wp_i),
        .hit     (cache_hit),
        .sel     (reg_sel),
        .cword   (cache_word),
        .fill    (do_fill),
        .pen     (pen_o),
        .valid_n (valid_n_o)
    );

endmodule

// File: rtl/blkprot_checker_sva.sv
// Module: blkprot_checker_sva
// Port-level properties of the checker, attached to the top module by bind.
// Assumes: the access inputs are stable while the strobe is high.
module blkprot_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic strobe_i,
    input logic xlat_ok_i,
    input logic prot_en_i,
    input logic wr_i,
    input logic init_wp_i,
    input logic pen_o,
    input logic valid_n_o
);
    // R8: a low strobe returns both outputs to their inactive levels.
    p_drop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> (!pen_o && valid_n_o));

    // R8: a presented result is held while the strobe stays high.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_n_o && strobe_i) |=> ($stable(pen_o) && !valid_n_o));

    // R6: no write is released while init write protect is on.
    p_initwp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_n_o && pen_o) |-> !($past(init_wp_i) && $past(wr_i)));

    // R7: a release without a valid result comes only from disabled checking.
    p_off_novalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pen_o) && valid_n_o) |-> !$past(prot_en_i));

    // R5: a result becomes valid only after strobe and translation success.
    p_valid_after_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_n_o) |-> ($past(strobe_i) && $past(xlat_ok_i)));

endmodule

bind blkprot_checker blkprot_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_i  (strobe_i),
    .xlat_ok_i (xlat_ok_i),
    .prot_en_i (prot_en_i),
    .wr_i      (wr_i),
    .init_wp_i (init_wp_i),
    .pen_o     (pen_o),
    .valid_n_o (valid_n_o)
);

// File: tb/blkprot_checker_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
// latency and result checks for each requirement.
module blkprot_checker_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic        xlat_ok_i = 1'b0;
    logic        prot_en_i = 1'b1;
    logic [9:0]  blk_i = '0;
    logic        wr_i = 1'b0;
    logic        init_wp_i = 1'b0;
    logic        tbl_we_i = 1'b0;
    logic [5:0]  tbl_idx_i = '0;
    logic [15:0] tbl_word_i = '0;
    logic        pen_o;
    logic        valid_n_o;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // Reference model state.
    bit [15:0] m_bits [64];
    int        m_region = -1;
    int        m_phase = 0;
    bit        m_pen = 1'b0;
    bit        m_vn = 1'b1;

    blkprot_checker u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .xlat_ok_i(xlat_ok_i),
        .prot_en_i(prot_en_i), .blk_i(blk_i), .wr_i(wr_i), .init_wp_i(init_wp_i),
        .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_word_i(tbl_word_i),
        .pen_o(pen_o), .valid_n_o(valid_n_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // Model update at each edge, then compare against the outputs; watchdog.
    always @(posedge clk) begin
        int r;
        int b;
        r = int'(blk_i) / 16;
        b = int'(blk_i) % 16;
        if (!rst_n) begin
            foreach (m_bits[i]) m_bits[i] = '0;
            m_region = -1; m_phase = 0; m_pen = 0; m_vn = 1;
        end else begin
            if (tbl_we_i) begin
                m_bits[tbl_idx_i] = tbl_word_i;
                if (m_region == int'(tbl_idx_i)) m_region = -1;
            end
            if (!strobe_i) begin
                m_pen = 0; m_vn = 1; m_phase = 0;
            end else if (m_phase == 0 && xlat_ok_i) begin
                if (!prot_en_i) begin
                    m_pen = 1; m_phase = 2;
                end else if (m_region == r) begin
                    m_pen = !(m_bits[r][b] || (init_wp_i && wr_i)); m_vn = 0; m_phase = 2;
                end else begin
                    m_region = r; m_phase = 1;
                end
            end else if (m_phase == 1) begin
                m_pen = !(m_bits[r][b] || (init_wp_i && wr_i)); m_vn = 0; m_phase = 2;
            end
        end
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
        #3;
        check(cur_req, int'(pen_o), int'(m_pen), "model pen_o");
        check(cur_req, int'(valid_n_o), int'(m_vn), "model valid_n_o");
    end

    task automatic tbl_write(input int idx, input logic [15:0] w);
        @(negedge clk);
        tbl_we_i = 1; tbl_idx_i = 6'(idx); tbl_word_i = w;
        @(negedge clk);
        tbl_we_i = 0;
    endtask

    // One access: measure clocks to the result, check it, then end the cycle.
    task automatic access(input int blk, input bit w, input bit en, input int exp_lat,
                          input bit exp_pen, input string req);
        int lat;
        @(negedge clk);
        cur_req = req;
        blk_i = 10'(blk); wr_i = w; prot_en_i = en; xlat_ok_i = 1; strobe_i = 1;
        lat = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            lat++;
            if (!valid_n_o || (!en && pen_o)) break;
        end
        check(req, lat, exp_lat, "latency");
        check(req, int'(pen_o), int'(exp_pen), "pen_o");
        check(req, int'(valid_n_o), en ? 0 : 1, "valid_n_o");
        strobe_i = 0; xlat_ok_i = 0;
        @(negedge clk);
        check("R8", int'(pen_o), 0, "pen_o after strobe drop");
        check("R8", int'(valid_n_o), 1, "valid_n_o after strobe drop");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(pen_o), 0, "reset pen_o");
        check("R1", int'(valid_n_o), 1, "reset valid_n_o");
        rst_n = 1;
        // R1: cleared bitmap, first access misses and is allowed.
        access(3 * 16 + 7, 0, 1, 2, 1, "R1");
        cur_req = "R2";
        tbl_write(2, 16'h0005);
        tbl_write(5, 16'h8000);
        access(2 * 16 + 1, 0, 1, 2, 1, "R4");   // miss, bit clear
        access(2 * 16 + 0, 0, 1, 1, 0, "R3");   // hit, bit set
        access(2 * 16 + 2, 1, 1, 1, 0, "R2");   // bit 2 set
        access(2 * 16 + 15, 0, 1, 1, 1, "R2");  // bit 15 clear
        access(5 * 16 + 15, 0, 1, 2, 0, "R4");  // new region, blocked
        access(5 * 16 + 14, 0, 1, 1, 1, "R4");  // now a hit
        // R9: rewrite the cached region.
        tbl_write(5, 16'h0000);
        access(5 * 16 + 15, 0, 1, 2, 1, "R9");
        // R6: init write protect.
        init_wp_i = 1;
        access(5 * 16 + 3, 1, 1, 1, 0, "R6");
        access(5 * 16 + 3, 0, 1, 1, 1, "R6");
        init_wp_i = 0;
        access(5 * 16 + 3, 1, 1, 1, 1, "R6");
        // R7: checking disabled, cache left on region 5.
        access(9 * 16 + 0, 0, 0, 1, 1, "R7");
        access(5 * 16 + 4, 0, 1, 1, 1, "R7");
        // R5: wait for translation success.
        @(negedge clk);
        cur_req = "R5";
        blk_i = 10'(2 * 16 + 0); wr_i = 0; prot_en_i = 1; strobe_i = 1; xlat_ok_i = 0;
        repeat (3) begin
            @(negedge clk);
            check("R5", int'(pen_o), 0, "pen_o before xlat");
            check("R5", int'(valid_n_o), 1, "valid_n_o before xlat");
        end
        xlat_ok_i = 1;
        @(negedge clk);
        check("R5", int'(valid_n_o), 1, "miss wait after xlat");
        @(negedge clk);
        check("R5", int'(valid_n_o), 0, "valid after xlat");
        check("R5", int'(pen_o), 0, "blocked after xlat");
        // R8: result held while strobe stays high.
        cur_req = "R8";
        repeat (4) begin
            @(negedge clk);
            check("R8", int'(valid_n_o), 0, "held valid_n_o");
            check("R8", int'(pen_o), 0, "held pen_o");
        end
        strobe_i = 0; xlat_ok_i = 0;
        @(negedge clk);
        check("R8", int'(valid_n_o), 1, "released valid_n_o");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule